// File: doc/BRIEF.md
# At-Speed Capture Clock Controller

This block owns the clock of one scan-test domain. In test mode it forwards a slow shift clock while patterns are loaded and unloaded, and holds scan-enable high. When a capture request arrives, it stops the slow clock cleanly and hands over to the fast functional clock. It lets through an exact burst of fast pulses: a launch pulse first, then one or more capture pulses. It then closes the fast path and restores the slow clock so that the responses can be shifted out.

The number of fast pulses and the number of suppressed fast cycles between them are configuration inputs. A mode input selects the launch scheme. In the capture-launched scheme, scan-enable falls during the quiet slow phase, well ahead of the burst. In the shift-launched scheme, the launch pulse arrives while scan-enable is still high and acts as one last shift. Scan-enable is then cleared at that same fast edge, one fast period before the capture pulse. Outside test mode the functional clock passes straight through and the burst logic stays idle.

The capture request is synchronized into the fast domain with a multi-flop synchronizer. The fast path is gated by a clock gate that can only change while the fast clock is low. The slow path is gated by an enable that changes only on the falling edge of the slow clock. Each handover waits for an acknowledge from the other side, so the two clocks never reach the output together.

Top module: `atspeed_clk_ctrl`

## Requirements
- R1: In test mode with no burst in progress, `clk_out` carries only slow-clock pulses, `scan_en` is 1 and `busy` is 0.
- R2: `clk_out` never shows a high or low phase shorter than half a fast-clock period, including across every slow/fast handover.
- R3: Each accepted request produces exactly `cfg_pulse_cnt` fast pulses on `clk_out` (4-bit unsigned, 1 to 15).
- R4: Consecutive fast pulses in a burst are `cfg_pulse_gap`+1 fast periods apart (4-bit unsigned; a value of 0 gives back-to-back pulses one fast period apart).
- R5: After the last fast pulse, slow-clock pulses resume on `clk_out` and `busy` returns to 0.
- R6: With `cfg_los`=0 (capture-launched), `scan_en` is 0 at every fast pulse of the burst and is 1 again once slow pulses resume.
- R7: With `cfg_los`=1 (shift-launched), `scan_en` is 1 at the first (launch) fast pulse and 0 at the second (capture) fast pulse.
- R8: A request with `cfg_pulse_cnt`=0 produces no fast pulse, and `busy` stays 0.
- R9: With `test_mode`=0, `clk_out` equals `fast_clk`, `scan_en` and `busy` are 0, and capture requests have no effect.
- R10: `busy` rises only after a rising edge of `capture_req`. A further rising edge while `busy` is 1 adds no pulses and starts no second burst.
- R11: After reset is released in test mode, `clk_out` carries slow pulses only, `busy` is 0 and `scan_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| slow_clk | input | 1 | Slow shift clock from the tester |
| fast_clk | input | 1 | Fast functional clock |
| test_mode | input | 1 | 1 selects scan-test operation, 0 passes the functional clock |
| capture_req | input | 1 | Asynchronous request; a rising edge starts one burst |
| cfg_pulse_cnt | input | CNT_W | Number of fast pulses in a burst |
| cfg_pulse_gap | input | GAP_W | Suppressed fast cycles between pulses |
| cfg_los | input | 1 | 1 selects shift-launched, 0 selects capture-launched |
| clk_out | output | 1 | Clock for the scan-test domain |
| scan_en | output | 1 | Scan-enable for the domain's flops |
| busy | output | 1 | High from request acceptance until the slow clock returns |

## Verification
The checks inside the design assume that `test_mode`, `cfg_pulse_cnt`, `cfg_pulse_gap` and `cfg_los` stay still while `busy` is high. They also assume that each `capture_req` pulse lasts longer than the fast-domain synchronizer needs to catch it. The bench changes configuration only while the block is idle, holds every request for five fast periods, and switches `test_mode` only while no burst is running. The two clocks are given unrelated phases, so no slow edge ever coincides with a fast edge. This lets the bench tell the two kinds of pulse on `clk_out` apart by their edge times alone.

// File: rtl/atspeed_occ_pkg.sv
package atspeed_occ_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HANDOFF = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_BURST   = 3'd3,
    ST_DRAIN   = 3'd4,
    ST_RETURN  = 3'd5
  } occ_state_e;

endpackage

// File: rtl/occ_sync.sv
module occ_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[i] <= RST_VAL;
          else        ff_q[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[i] <= RST_VAL;
          else        ff_q[i] <= ff_q[i-1];
        end
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/occ_clk_gate.sv
module occ_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);

  logic en_l;

  always_latch begin
    if (!clk_i) en_l = en_i;
  end

  assign gclk_o = clk_i & en_l;

  // R2
  always @(en_l) begin
    gate_quiet_high_chk: assert (clk_i !== 1'b1)
      else $error("gate enable moved while clock high");
  end

endmodule

// File: rtl/occ_burst_fsm.sv
module occ_burst_fsm
  import atspeed_occ_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int GAP_W      = 4,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             trig_edge,
  input  logic             slow_ack,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             cfg_los,
  output logic             slow_on,
  output logic             fast_en,
  output logic             scan_en,
  output logic             busy
);

  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam int SEEN_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);
  localparam logic [SET_W-1:0] SET_ONE = SET_W'(1);
  localparam logic [SET_W-1:0] SET_INI = SET_W'(SETTLE_CYC - 1);

  occ_state_e       state_q, state_d;
  logic [CNT_W-1:0] pulse_q, pulse_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [SET_W-1:0] settle_q, settle_d;
  logic             slow_on_q, slow_on_d;
  logic             fast_en_q, fast_en_d;
  logic             se_q, se_d;
  logic             busy_q, busy_d;

  always_comb begin
    state_d   = state_q;
    pulse_d   = pulse_q;
    gap_d     = gap_q;
    settle_d  = settle_q;
    slow_on_d = slow_on_q;
    fast_en_d = 1'b0;
    se_d      = se_q;
    busy_d    = busy_q;
    if (!test_mode) begin
      state_d   = ST_IDLE;
      slow_on_d = 1'b1;
      se_d      = 1'b0;
      busy_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          slow_on_d = 1'b1;
          se_d      = 1'b1;
          busy_d    = 1'b0;
          if (trig_edge && (cfg_cnt != '0)) begin
            state_d   = ST_HANDOFF;
            slow_on_d = 1'b0;
            busy_d    = 1'b1;
            pulse_d   = cfg_cnt;
          end
        end
        ST_HANDOFF: begin
          if (!slow_ack) begin
            state_d  = ST_SETTLE;
            settle_d = SET_INI;
            if (!cfg_los) se_d = 1'b0;
          end
        end
        ST_SETTLE: begin
          if (settle_q == '0) begin
            state_d = ST_BURST;
            gap_d   = '0;
          end else begin
            settle_d = settle_q - SET_ONE;
          end
        end
        ST_BURST: begin
          if (fast_en_q && cfg_los) se_d = 1'b0;
          if (gap_q == '0) begin
            fast_en_d = 1'b1;
            pulse_d   = pulse_q - CNT_ONE;
            gap_d     = cfg_gap;
            if (pulse_q == CNT_ONE) state_d = ST_DRAIN;
          end else begin
            gap_d = gap_q - GAP_ONE;
          end
        end
        ST_DRAIN: begin
          if (fast_en_q && cfg_los) se_d = 1'b0;
          state_d = ST_RETURN;
        end
        ST_RETURN: begin
          slow_on_d = 1'b1;
          se_d      = 1'b1;
          if (slow_ack) begin
            state_d = ST_IDLE;
            busy_d  = 1'b0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pulse_q   <= '0;
      gap_q     <= '0;
      settle_q  <= '0;
      slow_on_q <= 1'b1;
      fast_en_q <= 1'b0;
      se_q      <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      pulse_q   <= pulse_d;
      gap_q     <= gap_d;
      settle_q  <= settle_d;
      slow_on_q <= slow_on_d;
      fast_en_q <= fast_en_d;
      se_q      <= se_d;
      busy_q    <= busy_d;
    end
  end

  assign slow_on = slow_on_q;
  assign fast_en = fast_en_q;
  assign scan_en = se_q;
  assign busy    = busy_q;

  logic [SEEN_W-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen_q <= '0;
    else if (state_q == ST_IDLE) seen_q <= '0;
    else                        seen_q <= seen_q + SEEN_W'(fast_en_q);
  end

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n || !test_mode)
    (state_q == ST_DRAIN) |=> (seen_q == {1'b0, cfg_cnt}));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_en_q |-> !slow_ack);

  // R10
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !test_mode)
    $rose(busy_q) |-> $past(trig_edge));

  // R7
  los_se_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || !test_mode)
    (cfg_los && $fell(se_q)) |-> $past(fast_en_q));

  // R6
  loc_se_low_chk: assert property (@(posedge clk) disable iff (!rst_n || !test_mode)
    (!cfg_los && fast_en_q) |-> !se_q);

endmodule

// File: rtl/atspeed_clk_ctrl.sv
module atspeed_clk_ctrl #(
  parameter int CNT_W       = 4,
  parameter int GAP_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 4
) (
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             fast_clk,
  input  logic             test_mode,
  input  logic             capture_req,
  input  logic [CNT_W-1:0] cfg_pulse_cnt,
  input  logic [GAP_W-1:0] cfg_pulse_gap,
  input  logic             cfg_los,
  output logic             clk_out,
  output logic             scan_en,
  output logic             busy
);

  logic slow_clk_n;
  logic rst_f_n, rst_s_n;
  logic trig_s, trig_d_q, trig_edge;
  logic slow_on, slow_gate, slow_ack;
  logic fast_en, fast_g;

  assign slow_clk_n = ~slow_clk;

  occ_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_fast (
    .clk(fast_clk), .rst_n(rst_n), .d(1'b1), .q(rst_f_n));

  occ_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_slow (
    .clk(slow_clk_n), .rst_n(rst_n), .d(1'b1), .q(rst_s_n));

  occ_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_trig_sync (
    .clk(fast_clk), .rst_n(rst_f_n), .d(capture_req), .q(trig_s));

  always_ff @(posedge fast_clk or negedge rst_f_n) begin
    if (!rst_f_n) trig_d_q <= 1'b0;
    else          trig_d_q <= trig_s;
  end
  assign trig_edge = trig_s & ~trig_d_q;

  occ_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_slow_gate (
    .clk(slow_clk_n), .rst_n(rst_s_n), .d(slow_on), .q(slow_gate));

  occ_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_slow_ack (
    .clk(fast_clk), .rst_n(rst_f_n), .d(slow_gate), .q(slow_ack));

  occ_burst_fsm #(.CNT_W(CNT_W), .GAP_W(GAP_W), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk       (fast_clk),
    .rst_n     (rst_f_n),
    .test_mode (test_mode),
    .trig_edge (trig_edge),
    .slow_ack  (slow_ack),
    .cfg_cnt   (cfg_pulse_cnt),
    .cfg_gap   (cfg_pulse_gap),
    .cfg_los   (cfg_los),
    .slow_on   (slow_on),
    .fast_en   (fast_en),
    .scan_en   (scan_en),
    .busy      (busy)
  );

  occ_clk_gate u_fast_gate (
    .clk_i  (fast_clk),
    .en_i   (fast_en),
    .gclk_o (fast_g)
  );

  assign clk_out = test_mode ? ((slow_clk & slow_gate) | fast_g) : fast_clk;

endmodule

// File: tb/atspeed_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module atspeed_clk_ctrl_tb_top;

  logic       rst_n, slow_clk, fast_clk, test_mode, capture_req, cfg_los;
  logic [3:0] cfg_pulse_cnt, cfg_pulse_gap;
  logic       clk_out, scan_en, busy;

  atspeed_clk_ctrl dut_i (
    .rst_n(rst_n), .slow_clk(slow_clk), .fast_clk(fast_clk),
    .test_mode(test_mode), .capture_req(capture_req),
    .cfg_pulse_cnt(cfg_pulse_cnt), .cfg_pulse_gap(cfg_pulse_gap),
    .cfg_los(cfg_los), .clk_out(clk_out), .scan_en(scan_en), .busy(busy));

  // 250 MHz fast clock: rising edges at 2, 6, 10 ... ns
  initial begin
    fast_clk = 1'b0;
    forever #2 fast_clk = ~fast_clk;
  end
  // slow clock: rising edges at odd ns, never on a fast edge
  initial begin
    slow_clk = 1'b0;
    #1;
    forever #24 slow_clk = ~slow_clk;
  end

  int    checks = 0, failures = 0;
  bit    done = 1'b0;
  int    fast_n, slow_n, slow_se_bad, runt;
  longint last_fast, rise_t, fall_t, min_int, max_int;
  logic  se_lo, se_at0, se_at1;
  bit    busy_seen;

  initial begin
    runt = 0; rise_t = -1; fall_t = -1;
    fast_n = 0; slow_n = 0; slow_se_bad = 0; last_fast = -1;
    min_int = 0; max_int = 0; busy_seen = 1'b0;
  end

  always @(negedge fast_clk) se_lo = scan_en;
  always @(posedge busy) busy_seen = 1'b1;

  always @(negedge clk_out) begin
    if (rise_t >= 0 && ($time - rise_t) < 2) runt++;
    fall_t = $time;
  end

  always @(posedge clk_out) begin
    longint t;
    t = $time;
    if (fall_t >= 0 && (t - fall_t) < 2) runt++;
    rise_t = t;
    if ((t % 4) == 2) begin
      if (fast_n == 0) se_at0 = se_lo;
      else if (fast_n == 1) se_at1 = se_lo;
      if (last_fast >= 0) begin
        if (min_int == 0 || (t - last_fast) < min_int) min_int = t - last_fast;
        if ((t - last_fast) > max_int) max_int = t - last_fast;
      end
      last_fast = t;
      fast_n++;
    end else begin
      slow_n++;
      if (scan_en !== 1'b1) slow_se_bad++;
    end
  end

  task automatic clear_stats();
    fast_n = 0; slow_n = 0; slow_se_bad = 0; last_fast = -1;
    min_int = 0; max_int = 0; busy_seen = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge fast_clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  task automatic pulse_req();
    @(negedge fast_clk);
    capture_req = 1'b1;
    #20;
    capture_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy !== 1'b0; i++) @(negedge fast_clk);
  endtask

  // {count, gap, los}
  localparam logic [8:0] VECS [0:6] = '{
    {4'd2, 4'd0, 1'b0},
    {4'd2, 4'd0, 1'b1},
    {4'd3, 4'd1, 1'b0},
    {4'd4, 4'd2, 1'b1},
    {4'd1, 4'd0, 1'b0},
    {4'd2, 4'd3, 1'b1},
    {4'd15, 4'd0, 1'b0}
  };

  initial begin
    int r0;
    rst_n = 1'b0; test_mode = 1'b1; capture_req = 1'b0;
    cfg_pulse_cnt = 4'd2; cfg_pulse_gap = 4'd0; cfg_los = 1'b0;
    #100;
    @(negedge fast_clk); rst_n = 1'b1;
    #300;
    r0 = runt;
    clear_stats();
    #400;
    // R11 reset state
    chk(fast_n == 0, "R11 fast pulses after reset", fast_n, 0);
    chk(slow_n >= 6, "R11 slow pulses after reset", slow_n, 8);
    chk(busy === 1'b0, "R11 busy after reset", busy, 0);
    chk(scan_en === 1'b1, "R11 scan_en after reset", scan_en, 1);
    // R1 shift phase
    chk(slow_se_bad == 0, "R1 scan_en low at slow edge", slow_se_bad, 0);

    foreach (VECS[v]) begin
      logic [3:0] n, g;
      logic       los;
      n = VECS[v][8:5]; g = VECS[v][4:1]; los = VECS[v][0];
      cfg_pulse_cnt = n; cfg_pulse_gap = g; cfg_los = los;
      #100;
      r0 = runt;
      clear_stats();
      pulse_req();
      for (int i = 0; i < 200 && busy !== 1'b1; i++) @(negedge fast_clk);
      chk(busy === 1'b1, "R10 busy after request", busy, 1);
      wait_idle();
      chk(fast_n == n, "R3 fast pulse count", fast_n, n);
      if (n >= 2)
        chk(min_int == 4 * (g + 1) && max_int == 4 * (g + 1),
            "R4 pulse spacing ns", max_int, 4 * (g + 1));
      if (los) begin
        chk(se_at0 === 1'b1, "R7 scan_en at launch", se_at0, 1);
        if (n >= 2) chk(se_at1 === 1'b0, "R7 scan_en at capture", se_at1, 0);
      end else begin
        chk(se_at0 === 1'b0, "R6 scan_en at launch", se_at0, 0);
        if (n >= 2) chk(se_at1 === 1'b0, "R6 scan_en at capture", se_at1, 0);
      end
      slow_n = 0; slow_se_bad = 0;
      #300;
      chk(busy === 1'b0, "R5 busy cleared", busy, 0);
      chk(slow_n >= 4, "R5 slow pulses resumed", slow_n, 6);
      chk(slow_se_bad == 0, "R6 scan_en restored for unload", slow_se_bad, 0);
      chk(runt == r0, "R2 runt phases", runt - r0, 0);
    end

    // R8 zero-length burst
    cfg_pulse_cnt = 4'd0; cfg_los = 1'b0;
    #100;
    clear_stats();
    pulse_req();
    #400;
    chk(fast_n == 0, "R8 no fast pulse for count zero", fast_n, 0);
    chk(busy_seen == 1'b0, "R8 busy stayed low", busy_seen, 0);
    chk(slow_n >= 6, "R8 slow clock kept running", slow_n, 8);

    // R10 request during busy is ignored
    cfg_pulse_cnt = 4'd4; cfg_pulse_gap = 4'd6; cfg_los = 1'b1;
    #100;
    clear_stats();
    pulse_req();
    for (int i = 0; i < 200 && busy !== 1'b1; i++) @(negedge fast_clk);
    #40;
    pulse_req();
    wait_idle();
    busy_seen = 1'b0;
    #500;
    chk(fast_n == 4, "R10 pulses with request during busy", fast_n, 4);
    chk(busy_seen == 1'b0, "R10 no second burst", busy_seen, 0);

    // R9 functional mode
    cfg_pulse_cnt = 4'd2; cfg_pulse_gap = 4'd0; cfg_los = 1'b0;
    @(negedge fast_clk); test_mode = 1'b0;
    #100;
    @(negedge fast_clk);
    r0 = runt;
    clear_stats();
    #200;
    chk(fast_n == 50 && slow_n == 0, "R9 clk_out follows fast clock", fast_n, 50);
    chk(scan_en === 1'b0, "R9 scan_en in functional mode", scan_en, 0);
    chk(runt == r0, "R9 no runt in functional mode", runt - r0, 0);
    busy_seen = 1'b0;
    pulse_req();
    #300;
    chk(busy_seen == 1'b0, "R9 request ignored", busy_seen, 0);

    // back to test mode: R1 shift phase again
    @(negedge fast_clk); test_mode = 1'b1;
    #200;
    clear_stats();
    #400;
    chk(fast_n == 0 && slow_n >= 6, "R1 only slow pulses in shift", fast_n, 0);
    chk(scan_en === 1'b1 && busy === 1'b0, "R1 scan_en high and idle", scan_en, 1);

    finish_run();
  end

endmodule